// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives host software a way to reach a 32-bit internal register space that is not mapped directly. The host sees three 64-bit registers: a read-only description of an attached serial peripheral controller, a command register, and a completion register. One write of the command register holds the operation code, a 13-bit target address and 32 bits of write data. That write starts exactly one transfer on a simple internal request/acknowledge bus.

The internal bus sends a single-cycle request strobe that carries the write enable, the address and the write data. It answers with an acknowledge strobe that carries read data, any number of cycles later. On that acknowledge the bridge sets a valid flag in the completion register. For a read it also latches the returned data. Software polls the valid flag after each command write. Command writes that arrive while a transfer is still open are dropped, and so are commands that encode no operation.

Top module: `regwin_bridge`

## Requirements
- R1: After reset the completion register (offset 0x18) reads all zero, the command readback (offset 0x10) reads zero, and no request strobe is driven.
- R2: The register at offset 0x08 reads a constant built from parameters: bit 1 gives the shift order (1 means least significant bit first), bits 7:2 give the word width, bits 13:8 give the chip-select count, bit 14 gives clock polarity, bit 15 gives clock phase, and bits 47:32 give the peripheral identifier. All other bits read zero.
- R3: A host write at offset 0x10 while idle, with operation bits 63:62 equal to 1 (read) or 2 (write), drives one request strobe in the next cycle. The strobe carries write enable 1 only for code 2, the address from bits 44:32 and the data from bits 31:0.
- R4: Accepting a command clears the valid flag (completion bit 32) from the next cycle until the acknowledge.
- R5: An acknowledge for an open transfer sets the valid flag in the next cycle. For a read, completion bits 31:0 then hold the acknowledged data.
- R6: Completing a write leaves completion bits 31:0 at their previous value.
- R7: A command write with operation code 0 (no operation) or 3 (unused) starts no request and changes neither the completion register nor the command readback.
- R8: A command write while a transfer is open starts no request, and it does not change the completion register or the command readback. The open transfer still completes with its own result.
- R9: An acknowledge when no transfer is open changes nothing.
- R10: Offset 0x10 reads back the last accepted command with all unlisted bits zero. Completion bits 63:33 read zero, and any other offset reads zero.
- R11: The request strobe never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | HOST_AW | Host byte offset |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data for host_addr (combinational) |
| bus_req | output | 1 | Internal request strobe, one cycle |
| bus_we | output | 1 | Request is a write |
| bus_addr | output | 13 | Internal target address |
| bus_wdata | output | 32 | Internal write data |
| bus_ack | input | 1 | Internal acknowledge strobe |
| bus_rdata | input | 32 | Read data that goes with bus_ack |

## Verification
A stuck or lost busy state shows up at the ports in one of two ways. Either a command that should be dropped produces a second request strobe one cycle after its write, or a valid command produces no strobe at all and the valid flag stays low. A wrong captured operation type is visible one cycle after the acknowledge, as read data that changed after a write or stayed unchanged after a read. Because the valid flag is cleared at acceptance and set after acknowledge, any mistake in either transition appears at the first poll that follows.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  localparam int TGT_AW = 13;
  localparam int TGT_DW = 32;
  localparam int WORD_W = 64;

  localparam int OFS_PARAM = 8;
  localparam int OFS_CTRL  = 16;
  localparam int OFS_STAT  = 24;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_SPARE = 2'd3
  } op_e;

  function automatic logic [WORD_W-1:0] pack_param(
    input logic        lsb_first,
    input logic [5:0]  width,
    input logic [5:0]  ncs,
    input logic        cpol,
    input logic        cpha,
    input logic [15:0] ident);
    return {16'b0, ident, 16'b0, cpha, cpol, ncs, width, lsb_first, 1'b0};
  endfunction

  function automatic logic [WORD_W-1:0] pack_ctrl(
    input op_e               op,
    input logic [TGT_AW-1:0] addr,
    input logic [TGT_DW-1:0] data);
    return {op, 17'b0, addr, data};
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(
    input logic              valid,
    input logic [TGT_DW-1:0] data);
    return {31'b0, valid, data};
  endfunction

  function automatic op_e ctrl_op(input logic [WORD_W-1:0] w);
    return op_e'(w[63:62]);
  endfunction

  function automatic logic [TGT_AW-1:0] ctrl_addr(input logic [WORD_W-1:0] w);
    return w[44:32];
  endfunction

  function automatic logic [TGT_DW-1:0] ctrl_data(input logic [WORD_W-1:0] w);
    return w[31:0];
  endfunction

  function automatic logic op_launches(input op_e op);
    return (op == OP_READ) || (op == OP_WRITE);
  endfunction

endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int HOST_AW = 5
) (
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [WORD_W-1:0]  param_word,
  input  logic [WORD_W-1:0]  ctrl_word,
  input  logic [WORD_W-1:0]  stat_word,
  output logic               ctrl_wr,
  output logic [WORD_W-1:0]  host_rdata
);
  localparam logic [HOST_AW-1:0] A_PARAM = HOST_AW'(OFS_PARAM);
  localparam logic [HOST_AW-1:0] A_CTRL  = HOST_AW'(OFS_CTRL);
  localparam logic [HOST_AW-1:0] A_STAT  = HOST_AW'(OFS_STAT);

  assign ctrl_wr = host_we && (host_addr == A_CTRL);

  always_comb begin
    unique case (host_addr)
      A_PARAM: host_rdata = param_word;
      A_CTRL:  host_rdata = ctrl_word;
      A_STAT:  host_rdata = stat_word;
      default: host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/regwin_launch.sv
module regwin_launch
  import regwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              bus_ack,
  output logic              accept,
  output logic              complete,
  output logic              busy,
  output logic              cpl_read,
  output logic              bus_req,
  output logic              bus_we,
  output logic [TGT_AW-1:0] bus_addr,
  output logic [TGT_DW-1:0] bus_wdata,
  output logic [WORD_W-1:0] ctrl_word
);
  op_e               new_op;
  op_e               last_op;

  assign new_op   = ctrl_op(host_wdata);
  assign accept   = ctrl_wr && !busy && op_launches(new_op);
  assign complete = busy && bus_ack;
  assign cpl_read = (last_op == OP_READ);
  assign ctrl_word = pack_ctrl(last_op, bus_addr, bus_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      last_op   <= OP_NONE;
    end else begin
      bus_req <= accept;
      if (accept) begin
        busy      <= 1'b1;
        bus_we    <= (new_op == OP_WRITE);
        bus_addr  <= ctrl_addr(host_wdata);
        bus_wdata <= ctrl_data(host_wdata);
        last_op   <= new_op;
      end else if (complete) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/regwin_status.sv
module regwin_status
  import regwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              complete,
  input  logic              cpl_read,
  input  logic [TGT_DW-1:0] bus_rdata,
  output logic              stat_valid,
  output logic [TGT_DW-1:0] stat_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_valid <= 1'b0;
      stat_rdata <= '0;
    end else if (accept) begin
      stat_valid <= 1'b0;
    end else if (complete) begin
      stat_valid <= 1'b1;
      if (cpl_read) stat_rdata <= bus_rdata;
    end
  end
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
  import regwin_pkg::*;
#(
  parameter int          HOST_AW     = 5,
  parameter bit          P_LSB_FIRST = 1'b1,
  parameter int          P_WORD_BITS = 16,
  parameter int          P_CS_COUNT  = 3,
  parameter bit          P_CPOL      = 1'b1,
  parameter bit          P_CPHA      = 1'b0,
  parameter logic [15:0] P_PERIPH_ID = 16'hA55A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [63:0]        host_wdata,
  output logic [63:0]        host_rdata,
  output logic               bus_req,
  output logic               bus_we,
  output logic [12:0]        bus_addr,
  output logic [31:0]        bus_wdata,
  input  logic               bus_ack,
  input  logic [31:0]        bus_rdata
);
  localparam logic [5:0] WIDTH_F = 6'(P_WORD_BITS);
  localparam logic [5:0] NCS_F   = 6'(P_CS_COUNT);

  logic              ctrl_wr;
  logic              accept;
  logic              complete;
  logic              busy;
  logic              cpl_read;
  logic              stat_valid;
  logic [TGT_DW-1:0] stat_rdata;
  logic [WORD_W-1:0] param_word;
  logic [WORD_W-1:0] ctrl_word;
  logic [WORD_W-1:0] stat_word;

  assign param_word = pack_param(P_LSB_FIRST, WIDTH_F, NCS_F, P_CPOL, P_CPHA, P_PERIPH_ID);
  assign stat_word  = pack_status(stat_valid, stat_rdata);

  regwin_decode #(.HOST_AW(HOST_AW)) u_decode (
    .host_we    (host_we),
    .host_addr  (host_addr),
    .param_word (param_word),
    .ctrl_word  (ctrl_word),
    .stat_word  (stat_word),
    .ctrl_wr    (ctrl_wr),
    .host_rdata (host_rdata)
  );

  regwin_launch u_launch (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .host_wdata (host_wdata),
    .bus_ack    (bus_ack),
    .accept     (accept),
    .complete   (complete),
    .busy       (busy),
    .cpl_read   (cpl_read),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .ctrl_word  (ctrl_word)
  );

  regwin_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .complete   (complete),
    .cpl_read   (cpl_read),
    .bus_rdata  (bus_rdata),
    .stat_valid (stat_valid),
    .stat_rdata (stat_rdata)
  );
endmodule

// File: rtl/regwin_bridge_chk.sv
module regwin_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctrl_wr,
  input logic [63:0] host_wdata,
  input logic        bus_req,
  input logic        bus_ack,
  input logic        accept,
  input logic        complete,
  input logic        busy,
  input logic        cpl_read,
  input logic        stat_valid,
  input logic [31:0] stat_rdata
);
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> !bus_req); // R11
  AST_REQ_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> $past(accept)); // R3
  AST_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !stat_valid); // R4
  AST_SET_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> stat_valid); // R5
  AST_WRITE_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && !cpl_read) |=> $stable(stat_rdata)); // R6
  AST_NOOP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !busy && (host_wdata[63:62] == 2'd0 || host_wdata[63:62] == 2'd3))
      |=> (!bus_req && $stable(stat_valid) && $stable(stat_rdata))); // R7
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && busy && !bus_ack) |=> (!bus_req && $stable(stat_valid) && $stable(stat_rdata))); // R8
  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && !busy && !accept) |=> ($stable(stat_valid) && $stable(stat_rdata))); // R9
endmodule

bind regwin_bridge regwin_bridge_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_wr    (ctrl_wr),
  .host_wdata (host_wdata),
  .bus_req    (bus_req),
  .bus_ack    (bus_ack),
  .accept     (accept),
  .complete   (complete),
  .busy       (busy),
  .cpl_read   (cpl_read),
  .stat_valid (stat_valid),
  .stat_rdata (stat_rdata)
);

// File: tb/regwin_bridge_test.sv
`timescale 1ns/1ps
module regwin_bridge_test;
  localparam int AW = 5;
  localparam logic [AW-1:0] A_PAR = 5'd8, A_CMD = 5'd16, A_STS = 5'd24, A_NONE = 5'd0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic        bus_req, bus_we;
  logic [12:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  regwin_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [12:0] addr;
    logic [31:0] wdata;
    logic [31:0] ackdata;
    logic [3:0]  dly;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd1, 13'h0123, 32'h0000_0000, 32'hCAFE_0001, 4'd0},
    '{2'd2, 13'h1FFF, 32'hDEAD_BEEF, 32'h1111_2222, 4'd2},
    '{2'd1, 13'h0000, 32'h1234_5678, 32'h8000_0001, 4'd5},
    '{2'd2, 13'h0AAA, 32'h5555_AAAA, 32'h0000_0000, 4'd1},
    '{2'd1, 13'h1555, 32'hFFFF_FFFF, 32'h0F0F_F0F0, 4'd3},
    '{2'd2, 13'h0001, 32'h0000_0001, 32'hFFFF_FFFF, 4'd0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] cmd_word(input logic [1:0] op, input logic [12:0] a, input logic [31:0] d);
    logic [63:0] w;
    w = 64'd0;
    w[63:62] = op;
    w[44:32] = a;
    w[31:0]  = d;
    return w;
  endfunction

  task automatic host_write(input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input logic [AW-1:0] a, output logic [63:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic pulse_ack(input logic [31:0] d);
    bus_ack = 1'b1; bus_rdata = d;
    @(negedge clk);
    bus_ack = 1'b0;
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd, exp_stat, exp_cmd;
    logic [31:0] exp_data;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    host_read(A_STS, rd);  check("R1 status", rd, 64'd0);
    host_read(A_CMD, rd);  check("R1 cmd readback", rd, 64'd0);
    check("R1 no request", {63'd0, bus_req}, 64'd0);

    // R2 parameter word, built from defaults by its own arithmetic
    host_read(A_PAR, rd);
    check("R2 param", rd, (64'hA55A << 32) | (64'd0 << 15) | (64'd1 << 14)
                          | (64'd3 << 8) | (64'd16 << 2) | (64'd1 << 1));
    // R10 unmapped offset
    host_read(A_NONE, rd); check("R10 unmapped", rd, 64'd0);

    exp_data = 32'd0;
    foreach (VECS[i]) begin
      host_write(A_CMD, cmd_word(VECS[i].op, VECS[i].addr, VECS[i].wdata));
      check("R3 req", {63'd0, bus_req}, 64'd1);
      check("R3 we", {63'd0, bus_we}, {63'd0, VECS[i].op == 2'd2});
      check("R3 addr", {51'd0, bus_addr}, {51'd0, VECS[i].addr});
      check("R3 wdata", {32'd0, bus_wdata}, {32'd0, VECS[i].wdata});
      host_read(A_STS, rd);
      check("R4 valid cleared", rd, {31'd0, 1'b0, exp_data});
      for (int d = 0; d < VECS[i].dly; d++) begin
        @(negedge clk);
        check("R11 single pulse", {63'd0, bus_req}, 64'd0);
        host_read(A_STS, rd);
        check("R4 still clear", {63'd0, rd[32]}, 64'd0);
      end
      pulse_ack(VECS[i].ackdata);
      if (VECS[i].op == 2'd1) exp_data = VECS[i].ackdata;
      host_read(A_STS, rd);
      check(VECS[i].op == 2'd1 ? "R5 read complete" : "R6 write keeps data",
            rd, {31'd0, 1'b1, exp_data});
      host_read(A_CMD, rd);
      check("R10 cmd readback", rd, cmd_word(VECS[i].op, VECS[i].addr, VECS[i].wdata));
    end
    exp_cmd  = cmd_word(VECS[5].op, VECS[5].addr, VECS[5].wdata);
    exp_stat = {31'd0, 1'b1, exp_data};

    // R7 no-operation and spare codes
    host_write(A_CMD, cmd_word(2'd0, 13'h0777, 32'hAAAA_0000));
    check("R7 nop no req", {63'd0, bus_req}, 64'd0);
    host_read(A_STS, rd); check("R7 nop status", rd, exp_stat);
    host_write(A_CMD, cmd_word(2'd3, 13'h0778, 32'hBBBB_0000));
    check("R7 spare no req", {63'd0, bus_req}, 64'd0);
    host_read(A_STS, rd); check("R7 spare status", rd, exp_stat);
    host_read(A_CMD, rd); check("R7 cmd readback", rd, exp_cmd);

    // R9 stray acknowledge while idle
    pulse_ack(32'h7777_7777);
    host_read(A_STS, rd); check("R9 idle ack", rd, exp_stat);

    // R8 command while in flight
    host_write(A_CMD, cmd_word(2'd1, 13'h0042, 32'd0));
    check("R8 first req", {63'd0, bus_req}, 64'd1);
    host_write(A_CMD, cmd_word(2'd2, 13'h0099, 32'h9999_9999));
    check("R8 no second req", {63'd0, bus_req}, 64'd0);
    host_read(A_STS, rd); check("R8 status held", rd, {31'd0, 1'b0, exp_data});
    host_read(A_CMD, rd); check("R8 cmd readback", rd, cmd_word(2'd1, 13'h0042, 32'd0));
    pulse_ack(32'h4242_4242);
    host_read(A_STS, rd); check("R8 own result", rd, {31'd0, 1'b1, 32'h4242_4242});
    @(negedge clk);
    check("R8 nothing pending", {63'd0, bus_req}, 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule